// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block divides each bit on a CAN bus into quanta and decides when to sample the receive line and when a transmitter should launch its next bit. A one-cycle quantum enable, `tqTick`, drives it. An 8-bit configuration byte sets the length of the two time segments that follow the one-quantum synchronization segment. The same byte chooses between a single sample and a three-sample majority vote at the sample point.

Each bit has three outputs. `txStrobe` pulses at the start of the bit. `sampleValid` pulses once the bit has been sampled. `sampleBit` holds the sampled value, with recessive as 1 and dominant as 0. While `busIdle` is high, a recessive-to-dominant edge causes a hard synchronization. While `busIdle` is low, an edge in the first segment makes that segment one quantum longer, and an edge in the second segment makes that segment one quantum shorter. Only one such adjustment is made per bit.

Top module: `canBitTimer`

## Requirements
- R1: After reset, `sampleBit` is 1 and both `sampleValid` and `txStrobe` are 0.
- R2: In the configuration byte, bits 3:0 hold field A, bits 6:4 hold field B and bit 7 is the triple-sample flag. With no bus edges, a bit lasts 1 + (A+1) + (B+1) quantum ticks, counted between successive `txStrobe` pulses.
- R3: With bit 7 equal to 0, number the quanta of a bit from 0, the synchronization quantum being 0. The sampled value is `rxLine` at the tick that ends quantum A+1.
- R4: With bit 7 equal to 1, the sampled value is the majority of `rxLine` at the sample-point tick and at the two ticks just before it.
- R5: `sampleValid` is a one-cycle pulse. It is asserted in the clock cycle after the sample-point tick, and only after a tick.
- R6: `txStrobe` is a one-cycle pulse. It is asserted in the clock cycle after the tick that ends the last quantum of a bit.
- R7: When bit 7 is 1 and field A is 0, `cfgError` is 1 and the first segment is forced to 2 quanta. Otherwise `cfgError` is 0.
- R8: While `busIdle` is 1, a tick that sees `rxLine` fall from 1 (at the previous tick) to 0 restarts the bit. That quantum counts as synchronization, so the next sample follows after (first segment length) further ticks.
- R9: While `busIdle` is 0, such an edge inside the first segment (after quantum 0, before the sample point) delays the sample point and the end of the bit by one quantum.
- R10: While `busIdle` is 0, such an edge after the sample point and before the last quantum ends the bit one quantum early. An edge in quantum 0, or a second edge in the same bit, has no timing effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tqTick | input | 1 | One-cycle time-quantum enable |
| cfgByte | input | 8 | Timing configuration: bit 7 triple mode, bits 6:4 field B, bits 3:0 field A |
| rxLine | input | 1 | Received bus level (1 recessive, 0 dominant) |
| busIdle | input | 1 | High while no frame is in progress; selects hard synchronization |
| sampleBit | output | 1 | Most recent sampled bit value |
| sampleValid | output | 1 | One-cycle pulse after each sample |
| txStrobe | output | 1 | One-cycle pulse at each bit start |
| cfgError | output | 1 | Triple mode selected with a one-quantum first segment |

## Verification
With a steady recessive line in single and triple modes, the spacing between bit-start pulses is what separates a correct segment-length decode from an off-by-one. A directed 0,0,1 pattern across the three sample quanta tells majority voting apart from single sampling. Edges placed in the synchronization quantum, the first segment and the second segment, with the bus busy and then idle, separate hard synchronization from lengthening and shortening. Random configurations with random line toggles and random gaps between ticks are compared tick by tick with a reference model in the bench, which catches interactions such as a second edge in one bit.

// File: rtl/canBitPkg.sv
package canBitPkg;
  localparam int SEG1_W = 4;
  localparam int SEG2_W = 3;
  localparam int CFG_W  = 1 + SEG1_W + SEG2_W;
  localparam int LEN1_W = SEG1_W + 1;
  localparam int LEN2_W = SEG2_W + 1;
  localparam int POS_W  = $clog2((1 << SEG1_W) + (1 << SEG2_W) + 3);

  typedef struct packed {
    logic sampleTick;
    logic wrapTick;
    logic hardSync;
  } bitStrobes_t;
endpackage

// File: rtl/canBitCfg.sv
module canBitCfg
  import canBitPkg::*;
#(
  parameter int S1W  = SEG1_W,
  parameter int S2W  = SEG2_W,
  parameter int CW   = 1 + S1W + S2W,
  parameter int L1W  = S1W + 1,
  parameter int L2W  = S2W + 1
) (
  input  logic [CW-1:0]  cfgByte,
  output logic           tripleMode,
  output logic [L1W-1:0] len1,
  output logic [L2W-1:0] len2,
  output logic           cfgError
);
  logic [S1W-1:0] seg1Field;
  logic [S2W-1:0] seg2Field;

  assign seg1Field  = cfgByte[S1W-1:0];
  assign seg2Field  = cfgByte[S1W+S2W-1:S1W];
  assign tripleMode = cfgByte[CW-1];
  // triple mode needs two quanta before the sample point inside the bit
  assign cfgError   = tripleMode && (seg1Field == '0);

  always_comb begin
    if (cfgError) len1 = L1W'(2);
    else          len1 = {1'b0, seg1Field} + L1W'(1);
    len2 = {1'b0, seg2Field} + L2W'(1);
  end
endmodule

// File: rtl/canBitCtrl.sv
module canBitCtrl
  import canBitPkg::*;
#(
  parameter int L1W = LEN1_W,
  parameter int L2W = LEN2_W,
  parameter int PW  = POS_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tqTick,
  input  logic           busIdle,
  input  logic           edgeSeen,
  input  logic           tripleMode,
  input  logic [L1W-1:0] len1,
  input  logic [L2W-1:0] len2,
  output bitStrobes_t    strobes
);
  logic [PW-1:0] pos;
  logic          extended, shortened, adjusted;
  logic [PW-1:0] samplePos, lastPos;
  logic          inSeg1, inSeg2, resync, lengthen, shortenNow;

  assign samplePos = PW'(len1) + PW'(extended);
  assign lastPos   = PW'(len1) + PW'(len2) + PW'(extended) - PW'(shortened);
  assign inSeg1    = (pos != '0) && (pos < samplePos);
  assign inSeg2    = pos > samplePos;
  assign resync    = edgeSeen && !busIdle && !adjusted;
  assign lengthen  = resync && inSeg1;
  assign shortenNow = resync && inSeg2 && (pos < lastPos);

  always_comb begin
    strobes.hardSync   = edgeSeen && busIdle;
    strobes.sampleTick = tqTick && !strobes.hardSync && (pos == samplePos);
    strobes.wrapTick   = tqTick && !strobes.hardSync &&
                         ((pos >= lastPos) || (shortenNow && (pos + PW'(1) == lastPos)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos       <= '0;
      extended  <= 1'b0;
      shortened <= 1'b0;
      adjusted  <= 1'b0;
    end else if (strobes.hardSync) begin
      pos       <= PW'(1);
      extended  <= 1'b0;
      shortened <= 1'b0;
      adjusted  <= 1'b0;
    end else if (strobes.wrapTick) begin
      pos       <= '0;
      extended  <= 1'b0;
      shortened <= 1'b0;
      adjusted  <= 1'b0;
    end else if (tqTick) begin
      pos <= pos + PW'(1);
      if (lengthen) begin
        extended <= 1'b1;
        adjusted <= 1'b1;
      end
      if (shortenNow) begin
        shortened <= 1'b1;
        adjusted  <= 1'b1;
      end
    end
  end

  assert_hard_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hardSync |=> (pos == PW'(1)));
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrapTick |=> (pos == '0));
  assert_seg1_min_R7: assert property (@(posedge clk) disable iff (!rstN)
    tripleMode |-> (len1 >= L1W'(2)));
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tqTick |=> $stable(pos));
endmodule

// File: rtl/canBitData.sv
module canBitData
  import canBitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tqTick,
  input  logic        rxLine,
  input  logic        tripleMode,
  input  bitStrobes_t strobes,
  output logic        edgeSeen,
  output logic        sampleBit,
  output logic        sampleValid,
  output logic        txStrobe
);
  logic       prevBus;
  logic [1:0] history;
  logic       majority;

  assign edgeSeen = tqTick && prevBus && !rxLine;
  assign majority = (history[1] & history[0]) | (history[1] & rxLine) | (history[0] & rxLine);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBus     <= 1'b1;
      history     <= 2'b11;
      sampleBit   <= 1'b1;
      sampleValid <= 1'b0;
      txStrobe    <= 1'b0;
    end else begin
      sampleValid <= strobes.sampleTick;
      txStrobe    <= strobes.wrapTick;
      if (tqTick) begin
        prevBus <= rxLine;
        history <= {history[0], rxLine};
      end
      if (strobes.sampleTick) sampleBit <= tripleMode ? majority : rxLine;
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  assert_valid_after_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(tqTick));
  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> !txStrobe);
  assert_bit_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleBit));
endmodule

// File: rtl/canBitTimer.sv
module canBitTimer
  import canBitPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tqTick,
  input  logic [CFG_W-1:0] cfgByte,
  input  logic             rxLine,
  input  logic             busIdle,
  output logic             sampleBit,
  output logic             sampleValid,
  output logic             txStrobe,
  output logic             cfgError
);
  logic              tripleMode;
  logic [LEN1_W-1:0] len1;
  logic [LEN2_W-1:0] len2;
  logic              edgeSeen;
  bitStrobes_t       strobes;

  canBitCfg u_cfg (
    .cfgByte(cfgByte), .tripleMode(tripleMode), .len1(len1), .len2(len2), .cfgError(cfgError)
  );

  canBitCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tqTick(tqTick), .busIdle(busIdle), .edgeSeen(edgeSeen),
    .tripleMode(tripleMode), .len1(len1), .len2(len2), .strobes(strobes)
  );

  canBitData u_data (
    .clk(clk), .rstN(rstN), .tqTick(tqTick), .rxLine(rxLine), .tripleMode(tripleMode),
    .strobes(strobes), .edgeSeen(edgeSeen), .sampleBit(sampleBit),
    .sampleValid(sampleValid), .txStrobe(txStrobe)
  );
endmodule

// File: tb/canBitTimer_tb.sv
module canBitTimer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tqTick = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       rxLine = 1'b1;
  logic       busIdle = 1'b0;
  logic       sampleBit, sampleValid, txStrobe, cfgError;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  // reference model state
  int mPos = 0, mExt = 0, mShrt = 0, mAdj = 0;
  bit mPrev = 1, mH1 = 1, mH0 = 1, mBit = 1;
  int tickNo = 0, lastTx = -1, prevTx = -1, lastValid = -1;

  always #10 clk = ~clk;

  canBitTimer u_dut (
    .clk(clk), .rstN(rstN), .tqTick(tqTick), .cfgByte(cfgByte), .rxLine(rxLine),
    .busIdle(busIdle), .sampleBit(sampleBit), .sampleValid(sampleValid),
    .txStrobe(txStrobe), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int seg1Len(input logic [7:0] c);
    return (c[7] && c[3:0] == 0) ? 2 : int'(c[3:0]) + 1;
  endfunction

  function automatic bit vote(input bit a, input bit b, input bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic resetModel();
    mPos = 0; mExt = 0; mShrt = 0; mAdj = 0;
    mPrev = 1; mH1 = 1; mH0 = 1; mBit = 1;
  endtask

  // one quantum tick followed by gap idle cycles
  task automatic doTick(input bit rx, input bit idle, input int gap);
    int  sp, last;
    bit  edgeB, hs, lng, shr, smp, wr;
    sp    = seg1Len(cfgByte) + mExt;
    last  = seg1Len(cfgByte) + int'(cfgByte[6:4]) + 1 + mExt - mShrt;
    edgeB = mPrev && !rx;
    hs    = edgeB && idle;
    lng   = edgeB && !idle && !mAdj && mPos >= 1 && mPos < sp;
    shr   = edgeB && !idle && !mAdj && mPos > sp && mPos < last;
    smp   = !hs && mPos == sp;
    wr    = !hs && (mPos >= last || (shr && mPos + 1 == last));
    if (smp) mBit = cfgByte[7] ? vote(mH1, mH0, rx) : rx;
    if (hs) begin mPos = 1; mExt = 0; mShrt = 0; mAdj = 0; end
    else if (wr) begin mPos = 0; mExt = 0; mShrt = 0; mAdj = 0; end
    else begin
      mPos++;
      if (lng) begin mExt = 1; mAdj = 1; end
      if (shr) begin mShrt = 1; mAdj = 1; end
    end
    mH1 = mH0; mH0 = rx; mPrev = rx;

    rxLine = rx; busIdle = idle; tqTick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tqTick = 1'b0;
    tickNo++;
    check(sampleValid == smp, "R5 sampleValid", sampleValid, smp);
    check(txStrobe == wr, "R6 txStrobe", txStrobe, wr);
    check(sampleBit == mBit, cfgByte[7] ? "R4 sampleBit" : "R3 sampleBit", sampleBit, mBit);
    check(cfgError == (cfgByte[7] && cfgByte[3:0] == 0), "R7 cfgError", cfgError,
          (cfgByte[7] && cfgByte[3:0] == 0));
    if (txStrobe) begin prevTx = lastTx; lastTx = tickNo; end
    if (sampleValid) lastValid = tickNo;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check(!sampleValid && !txStrobe, "R5 R6 no pulse without tick",
            {sampleValid, txStrobe}, 0);
    end
  endtask

  // run recessive ticks until a bit starts
  task automatic alignToBit(input bit idle);
    int n = 0;
    while (!txStrobe && n < 40) begin doTick(1'b1, idle, 0); n++; end
  endtask

  initial begin
    int start;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    check(sampleBit == 1'b1, "R1 reset sampleBit", sampleBit, 1);
    check(!sampleValid && !txStrobe, "R1 reset strobes", {sampleValid, txStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: A=1, B=2, no edges -> 6 ticks per bit
    cfgByte = 8'h21;
    alignToBit(0); alignToBit(0);
    doTick(1'b1, 0, 1); alignToBit(0);
    check(lastTx - prevTx == 6, "R2 bit length 0x21", lastTx - prevTx, 6);

    // R7: triple with A=0 clamps first segment to 2 -> 1+2+1 = 4
    cfgByte = 8'h80;
    alignToBit(0); doTick(1'b1, 0, 0); alignToBit(0);
    check(cfgError == 1'b1, "R7 flag set", cfgError, 1);
    check(lastTx - prevTx == 4, "R7 clamped bit length", lastTx - prevTx, 4);

    // R4: triple, A=1; samples at quanta 0,1,2 = 0,0,1 -> majority 0
    cfgByte = 8'h81;
    alignToBit(0);
    doTick(1'b0, 0, 0); doTick(1'b0, 0, 0); doTick(1'b1, 0, 0);
    check(sampleValid && sampleBit == 1'b0, "R4 majority of 0,0,1", sampleBit, 0);
    // R3: single mode, same pattern -> sampled value 1
    cfgByte = 8'h01;
    alignToBit(0);
    doTick(1'b0, 0, 0); doTick(1'b0, 0, 0); doTick(1'b1, 0, 0);
    check(sampleValid && sampleBit == 1'b1, "R3 single sample", sampleBit, 1);

    // R9: A=3, B=0 (6 quanta); edge in quantum 2 lengthens to 7
    cfgByte = 8'h03;
    alignToBit(0); start = lastTx;
    doTick(1'b1, 0, 0); doTick(1'b1, 0, 0); doTick(1'b0, 0, 0);
    for (int k = 0; k < 6 && lastTx == start; k++) doTick(1'b0, 0, 0);
    check(lastTx - start == 7, "R9 lengthened bit", lastTx - start, 7);

    // R10: A=0, B=3 (6 quanta); edge in quantum 3 shortens to 5
    cfgByte = 8'h30;
    doTick(1'b1, 0, 0); alignToBit(0); start = lastTx;
    doTick(1'b1, 0, 0); doTick(1'b1, 0, 0); doTick(1'b1, 0, 0); doTick(1'b0, 0, 0);
    for (int k = 0; k < 6 && lastTx == start; k++) doTick(1'b0, 0, 0);
    check(lastTx - start == 5, "R10 shortened bit", lastTx - start, 5);
    // R10: edge in quantum 0 has no effect -> 6 quanta
    doTick(1'b1, 0, 0); alignToBit(0); start = lastTx;
    doTick(1'b0, 0, 0);
    for (int k = 0; k < 8 && lastTx == start; k++) doTick(1'b0, 0, 0);
    check(lastTx - start == 6, "R10 sync-quantum edge ignored", lastTx - start, 6);

    // R8: idle bus, A=2; edge restarts, sample 3 ticks later
    cfgByte = 8'h02;
    for (int k = 0; k < 3; k++) doTick(1'b1, 1, 0);
    doTick(1'b0, 1, 0); start = tickNo;
    for (int k = 0; k < 3; k++) doTick(1'b0, 1, 0);
    check(lastValid - start == 3, "R8 hard sync sample delay", lastValid - start, 3);

    // random configurations and line activity against the model
    for (int s = 0; s < 40; s++) begin
      bit rx = 1'b1;
      bit idle;
      cfgByte = 8'($urandom);
      idle = ($urandom % 4) == 0;
      for (int t = 0; t < 50; t++) begin
        if ($urandom % 4 == 0) rx = ~rx;
        doTick(rx, idle, int'($urandom % 3));
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule